// File: doc/BRIEF.md
# Instruction cache parity scanner

This block walks every way of one instruction-cache set and checks the parity bits stored next to each tag and each instruction doubleword. A caller loads a set index and a flag that turns on data checking, then pulses `start`. The scanner then issues array reads, one at a time, through a request/response port. For each way it first reads the tag. When data checking is on, it then reads the four doublewords of the line.

Each response is checked by combinational logic as it arrives. The tag checks cover the valid-bit copy and two tag-segment parities. The data checks cover the predecode parity and the per-byte parity of two 32-bit instructions. Faults from all ways are merged into a sticky error word, which is ready in the same cycle as a one-cycle `done` pulse. The scanner also returns the replacement ordering of the set, taken from way 0's tag.

Top module: `ic_parity_scanner`

## Requirements
- R1: Each tag read has `rd_kind`=0 and address `(way << 13) | (set_index & 0x1FE0)`. The ways are read in the order 0,1,2,3. Index bits outside 12:5 never reach the address.
- R2: With `check_data`=1, the tag read of a way is followed by four data reads (`rd_kind`=1) at address `(way << 13) | index | (dw << 3)` for dw = 0..3, giving 20 reads per scan. With `check_data`=0 only the 4 tag reads occur, and data content has no effect on the result.
- R3: `rd_req` is high for exactly one cycle per read. No new request is made until `rd_valid` has returned for the previous one, whatever the response latency.
- R4: A tag response whose tag-high bit 29 (valid) differs from tag-high bit 27 (valid copy) sets error bit 29. This holds whether the line is valid or not.
- R5: For a valid line, tag-low bit 10 must equal the XOR of tag-low bits 23:0 excluding bits 10 and 11. A mismatch sets error bit 29. For an invalid line the check is skipped.
- R6: For a valid line, tag-low bit 11 must equal the XOR of tag-low bits 63:24. A mismatch sets error bit 29. For an invalid line the check is skipped.
- R7: For a data response, data-high bit 16 must equal the XOR of data-high bits 15:8 (predecode). A mismatch sets error bit 28.
- R8: Instruction a is `rsp_lo[63:32]` and instruction b is `rsp_lo[31:0]`. Data-high bit 4+j must equal the XOR of byte j of a, and bit j must equal the XOR of byte j of b (j=3 is the most significant byte). Any mismatch sets error bit 28.
- R9: Faults from all ways and all doublewords are ORed together. Only bits 29 and 28 of `err_word` can ever be set.
- R10: `lru_order` takes way 0's tag-high bits 21:14, holding four 2-bit way numbers from least (low bits) to most recently used. Other ways' tags do not change it.
- R11: `done` pulses for one cycle, in the cycle after the last response is accepted, with `err_word` already final. `err_word` is cleared when a scan starts and otherwise holds its value until the next start.
- R12: A `start` while the scanner is busy is ignored. The running scan keeps its index and mode, and it gives exactly one `done`.
- R13: A synchronous reset returns the scanner to idle with `busy`, `done` and `rd_req` low and `err_word` and `lru_order` zero, including in the middle of a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a scan (taken only when idle) |
| set_index | input | ADDR_W | Set index; only bits 12:5 are used |
| check_data | input | 1 | 1 = also read and check the instruction doublewords |
| rd_req | output | 1 | One-cycle array read request |
| rd_kind | output | 1 | 0 = tag read, 1 = data read |
| rd_addr | output | ADDR_W | Array address of the request |
| rd_valid | input | 1 | Response valid for the outstanding read |
| rsp_hi | input | 32 | Tag-high or data-high response word |
| rsp_lo | input | 64 | Tag-low word, or instruction a (63:32) and b (31:0) |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |
| err_word | output | 32 | Bit 29 tag fault, bit 28 data fault |
| lru_order | output | NUM_WAYS*log2(NUM_WAYS) | Replacement order of the set, LRU first |

## Verification
The bench sweeps single-bit faults over every way, every doubleword and every parity field. It flips both the parity bit and a covered bit. A design with a byte order reversed within the parity nibble, or a field boundary off by one, would miss or misplace about half of these faults.

Segment faults on invalid lines must be ignored, while a flipped valid-bit copy on an invalid line must still be reported. A design that gates the valid-copy check on the valid bit would be silent there.

Response latency is varied from one scan to the next. A scanner that issues the next read early would be caught by the outstanding-read counter and by a wrong address log. A `start` pulsed in the middle of a scan, and a reset in the middle of a scan, would expose a design that re-latches the index, clears the error word, or signals `done` twice.

// File: rtl/ic_scan_pkg.sv
package ic_scan_pkg;

   typedef enum logic [2:0] {
      SC_IDLE     = 3'd0,
      SC_TAG_REQ  = 3'd1,
      SC_TAG_WAIT = 3'd2,
      SC_DAT_REQ  = 3'd3,
      SC_DAT_WAIT = 3'd4
   } scan_state_e;

   // response word widths
   localparam int HI_W   = 32;
   localparam int LO_W   = 64;
   localparam int INST_W = 32;
   localparam int ERR_W  = 32;

   // tag-high layout
   localparam int VLD_BIT     = 29;
   localparam int VLD_CPY_BIT = 27;

   // tag-low layout
   localparam int SEG0_PBIT = 10;
   localparam int SEG1_PBIT = 11;
   localparam int SEG0_MSB  = 23;
   localparam int SEG1_LSB  = 24;

   // data-high layout
   localparam int PDC_LSB   = 8;
   localparam int PDC_W     = 8;
   localparam int PDC_PBIT  = 16;
   localparam int BPAR_LSB  = 0;

   // error word layout
   localparam int ERR_TAG_BIT  = 29;
   localparam int ERR_DATA_BIT = 28;

endpackage

// File: rtl/ic_byte_parity.sv
module ic_byte_parity #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0]   word,
   output logic [WORD_W/8-1:0] par
);

   localparam int NBYTES = WORD_W / 8;

   if ((WORD_W % 8) != 0 || WORD_W < 8) begin : g_bad_width
      $error("ic_byte_parity: WORD_W must be a positive multiple of 8");
   end

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      assign par[g] = ^word[8*g +: 8];
   end

endmodule

// File: rtl/ic_tag_parity.sv
module ic_tag_parity
   import ic_scan_pkg::*;
(
   input  logic [HI_W-1:0] tag_hi,
   input  logic [LO_W-1:0] tag_lo,
   output logic            vld_flt,
   output logic            seg_flt,
   output logic            any_flt
);

   localparam logic [LO_W-1:0] ONES = '1;
   localparam logic [LO_W-1:0] SEG0_MASK =
      (ONES >> (LO_W - 1 - SEG0_MSB)) &
      ~(LO_W'(1) << SEG0_PBIT) & ~(LO_W'(1) << SEG1_PBIT);
   localparam logic [LO_W-1:0] SEG1_MASK = ONES << SEG1_LSB;

   logic line_vld;
   logic seg0_calc;
   logic seg1_calc;
   logic seg0_bad;
   logic seg1_bad;
   logic unused_tag_hi;

   assign line_vld  = tag_hi[VLD_BIT];
   assign seg0_calc = ^(tag_lo & SEG0_MASK);
   assign seg1_calc = ^(tag_lo & SEG1_MASK);
   assign seg0_bad  = tag_lo[SEG0_PBIT] ^ seg0_calc;
   assign seg1_bad  = tag_lo[SEG1_PBIT] ^ seg1_calc;

   assign vld_flt = line_vld ^ tag_hi[VLD_CPY_BIT];
   assign seg_flt = line_vld & (seg0_bad | seg1_bad);
   assign any_flt = vld_flt | seg_flt;

   assign unused_tag_hi = ^tag_hi;

endmodule

// File: rtl/ic_data_parity.sv
module ic_data_parity
   import ic_scan_pkg::*;
(
   input  logic [HI_W-1:0] dat_hi,
   input  logic [LO_W-1:0] dat_lo,
   output logic            pdc_flt,
   output logic            inst_flt,
   output logic            any_flt
);

   localparam int N_INST = LO_W / INST_W;
   localparam int NB     = INST_W / 8;

   logic [N_INST-1:0] slot_bad;
   logic              unused_dat_hi;

   if (N_INST * INST_W != LO_W) begin : g_bad_split
      $error("ic_data_parity: LO_W must hold a whole number of instructions");
   end

   // slot 0 is the low instruction (b), slot 1 the high one (a); parity nibbles follow
   for (genvar i = 0; i < N_INST; i++) begin : g_slot
      logic [NB-1:0] calc;
      ic_byte_parity #(.WORD_W(INST_W)) u_bp (
         .word (dat_lo[i*INST_W +: INST_W]),
         .par  (calc)
      );
      assign slot_bad[i] = |(calc ^ dat_hi[BPAR_LSB + i*NB +: NB]);
   end

   assign pdc_flt  = dat_hi[PDC_PBIT] ^ (^dat_hi[PDC_LSB +: PDC_W]);
   assign inst_flt = |slot_bad;
   assign any_flt  = pdc_flt | inst_flt;

   assign unused_dat_hi = ^dat_hi;

endmodule

// File: rtl/ic_scan_ctrl.sv
module ic_scan_ctrl
   import ic_scan_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int NUM_WAYS  = 4,
   parameter int NUM_DW    = 4,
   parameter int WAY_SHIFT = 13,
   parameter int IDX_MSB   = 12,
   parameter int IDX_LSB   = 5,
   parameter int DW_SHIFT  = 3,
   parameter bit DATA_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] set_index,
   input  logic              check_data,
   input  logic              rd_valid,
   output logic              rd_req,
   output logic              rd_kind,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              busy,
   output logic              done,
   output logic              scan_clear,
   output logic              tag_take,
   output logic              data_take,
   output logic              first_way
);

   localparam int WAY_W = $clog2(NUM_WAYS);
   localparam int DW_W  = $clog2(NUM_DW);
   localparam logic [ADDR_W-1:0] ONES     = '1;
   localparam logic [ADDR_W-1:0] IDX_MASK =
      (ONES >> (ADDR_W - 1 - IDX_MSB)) & (ONES << IDX_LSB);
   localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);
   localparam logic [DW_W-1:0]  LAST_DW  = DW_W'(NUM_DW - 1);

   if (NUM_WAYS < 2 || (1 << WAY_W) != NUM_WAYS) begin : g_bad_ways
      $error("ic_scan_ctrl: NUM_WAYS must be a power of two, at least 2");
   end
   if (NUM_DW < 2 || (1 << DW_W) != NUM_DW) begin : g_bad_dw
      $error("ic_scan_ctrl: NUM_DW must be a power of two, at least 2");
   end
   if (WAY_SHIFT + WAY_W > ADDR_W || IDX_MSB >= WAY_SHIFT) begin : g_bad_way_field
      $error("ic_scan_ctrl: way field must sit above the index inside ADDR_W");
   end
   if (DW_SHIFT + DW_W > IDX_LSB || IDX_LSB > IDX_MSB) begin : g_bad_dw_field
      $error("ic_scan_ctrl: doubleword field must sit below the index");
   end

   scan_state_e       st_q, st_d;
   logic [WAY_W-1:0]  way_q, way_d;
   logic [DW_W-1:0]   dw_q, dw_d;
   logic [ADDR_W-1:0] idx_q;
   logic              chk_q;
   logic              chk_en;
   logic              done_q, done_d;
   logic              last_way;
   logic              last_dw;
   logic [ADDR_W-1:0] way_part;
   logic [ADDR_W-1:0] dw_part;

   // variant: data reads may be removed altogether
   if (DATA_EN) begin : g_data_on
      assign chk_en = check_data;
   end else begin : g_data_off
      logic unused_chk;
      assign unused_chk = check_data;
      assign chk_en     = 1'b0;
   end

   assign last_way = (way_q == LAST_WAY);
   assign last_dw  = (dw_q == LAST_DW);

   always_comb begin
      st_d   = st_q;
      way_d  = way_q;
      dw_d   = dw_q;
      done_d = 1'b0;
      case (st_q)
         SC_IDLE: begin
            if (start) begin
               st_d  = SC_TAG_REQ;
               way_d = '0;
               dw_d  = '0;
            end
         end
         SC_TAG_REQ: st_d = SC_TAG_WAIT;
         SC_TAG_WAIT: begin
            if (rd_valid) begin
               if (chk_q) begin
                  st_d = SC_DAT_REQ;
                  dw_d = '0;
               end else if (last_way) begin
                  st_d   = SC_IDLE;
                  done_d = 1'b1;
               end else begin
                  way_d = way_q + WAY_W'(1);
                  st_d  = SC_TAG_REQ;
               end
            end
         end
         SC_DAT_REQ: st_d = SC_DAT_WAIT;
         SC_DAT_WAIT: begin
            if (rd_valid) begin
               if (!last_dw) begin
                  dw_d = dw_q + DW_W'(1);
                  st_d = SC_DAT_REQ;
               end else if (last_way) begin
                  st_d   = SC_IDLE;
                  done_d = 1'b1;
               end else begin
                  way_d = way_q + WAY_W'(1);
                  st_d  = SC_TAG_REQ;
               end
            end
         end
         default: st_d = SC_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= SC_IDLE;
         way_q  <= '0;
         dw_q   <= '0;
         idx_q  <= '0;
         chk_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         way_q  <= way_d;
         dw_q   <= dw_d;
         done_q <= done_d;
         if (st_q == SC_IDLE && start) begin
            idx_q <= set_index & IDX_MASK;
            chk_q <= chk_en;
         end
      end
   end

   assign way_part = ADDR_W'(way_q) << WAY_SHIFT;
   assign dw_part  = (st_q == SC_DAT_REQ || st_q == SC_DAT_WAIT) ?
                     (ADDR_W'(dw_q) << DW_SHIFT) : '0;

   assign rd_req     = (st_q == SC_TAG_REQ) || (st_q == SC_DAT_REQ);
   assign rd_kind    = (st_q == SC_DAT_REQ) || (st_q == SC_DAT_WAIT);
   assign rd_addr    = way_part | idx_q | dw_part;
   assign busy       = (st_q != SC_IDLE);
   assign done       = done_q;
   assign scan_clear = (st_q == SC_IDLE) && start;
   assign tag_take   = (st_q == SC_TAG_WAIT) && rd_valid;
   assign data_take  = (st_q == SC_DAT_WAIT) && rd_valid;
   assign first_way  = (way_q == '0);

endmodule

// File: rtl/ic_parity_scanner.sv
module ic_parity_scanner
   import ic_scan_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int NUM_WAYS  = 4,
   parameter int NUM_DW    = 4,
   parameter int WAY_SHIFT = 13,
   parameter int IDX_MSB   = 12,
   parameter int IDX_LSB   = 5,
   parameter int DW_SHIFT  = 3,
   parameter int LRU_LSB   = 14,
   parameter bit DATA_EN   = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  start,
   input  logic [ADDR_W-1:0]                     set_index,
   input  logic                                  check_data,
   output logic                                  rd_req,
   output logic                                  rd_kind,
   output logic [ADDR_W-1:0]                     rd_addr,
   input  logic                                  rd_valid,
   input  logic [31:0]                           rsp_hi,
   input  logic [63:0]                           rsp_lo,
   output logic                                  busy,
   output logic                                  done,
   output logic [31:0]                           err_word,
   output logic [NUM_WAYS*$clog2(NUM_WAYS)-1:0]  lru_order
);

   localparam int WAY_W = $clog2(NUM_WAYS);
   localparam int LRU_W = NUM_WAYS * WAY_W;

   if (LRU_LSB + LRU_W > HI_W) begin : g_bad_lru
      $error("ic_parity_scanner: replacement field does not fit in tag-high");
   end

   logic             scan_clear;
   logic             tag_take;
   logic             data_take;
   logic             first_way;
   logic             tag_flt;
   logic             tag_vld_flt;
   logic             tag_seg_flt;
   logic             data_flt;
   logic [ERR_W-1:0] err_q;
   logic [LRU_W-1:0] lru_q;
   logic             unused_flt;

   ic_scan_ctrl #(
      .ADDR_W    (ADDR_W),
      .NUM_WAYS  (NUM_WAYS),
      .NUM_DW    (NUM_DW),
      .WAY_SHIFT (WAY_SHIFT),
      .IDX_MSB   (IDX_MSB),
      .IDX_LSB   (IDX_LSB),
      .DW_SHIFT  (DW_SHIFT),
      .DATA_EN   (DATA_EN)
   ) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .set_index  (set_index),
      .check_data (check_data),
      .rd_valid   (rd_valid),
      .rd_req     (rd_req),
      .rd_kind    (rd_kind),
      .rd_addr    (rd_addr),
      .busy       (busy),
      .done       (done),
      .scan_clear (scan_clear),
      .tag_take   (tag_take),
      .data_take  (data_take),
      .first_way  (first_way)
   );

   ic_tag_parity u_tag (
      .tag_hi  (rsp_hi),
      .tag_lo  (rsp_lo),
      .vld_flt (tag_vld_flt),
      .seg_flt (tag_seg_flt),
      .any_flt (tag_flt)
   );

   if (DATA_EN) begin : g_data_chk
      logic pdc_flt;
      logic inst_flt;
      ic_data_parity u_data (
         .dat_hi   (rsp_hi),
         .dat_lo   (rsp_lo),
         .pdc_flt  (pdc_flt),
         .inst_flt (inst_flt),
         .any_flt  (data_flt)
      );
      logic unused_parts;
      assign unused_parts = pdc_flt ^ inst_flt;
   end else begin : g_no_data_chk
      assign data_flt = 1'b0;
   end

   assign unused_flt = tag_vld_flt ^ tag_seg_flt;

   // sticky fault accumulation across every way and doubleword
   always_ff @(posedge clk) begin
      if (rst) begin
         err_q <= '0;
      end else if (scan_clear) begin
         err_q <= '0;
      end else begin
         if (tag_take && tag_flt) begin
            err_q[ERR_TAG_BIT] <= 1'b1;
         end
         if (data_take && data_flt) begin
            err_q[ERR_DATA_BIT] <= 1'b1;
         end
      end
   end

   // replacement order comes only from the first way's tag
   always_ff @(posedge clk) begin
      if (rst) begin
         lru_q <= '0;
      end else if (tag_take && first_way) begin
         lru_q <= rsp_hi[LRU_LSB +: LRU_W];
      end
   end

   assign err_word  = err_q;
   assign lru_order = lru_q;

endmodule

// File: rtl/ic_parity_scanner_chk.sv
module ic_parity_scanner_chk #(
   parameter int ADDR_W    = 16,
   parameter int NUM_WAYS  = 4,
   parameter int NUM_DW    = 4,
   parameter int WAY_SHIFT = 13,
   parameter int IDX_MSB   = 12,
   parameter int IDX_LSB   = 5,
   parameter int DW_SHIFT  = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              check_data,
   input logic              rd_req,
   input logic              rd_kind,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_valid,
   input logic              busy,
   input logic              done,
   input logic [31:0]       err_word
);

   localparam int WAY_W = $clog2(NUM_WAYS);
   localparam int DW_W  = $clog2(NUM_DW);
   localparam logic [ADDR_W-1:0] ONES      = '1;
   localparam logic [ADDR_W-1:0] IDX_FIELD =
      (ONES >> (ADDR_W - 1 - IDX_MSB)) & (ONES << IDX_LSB);
   localparam logic [ADDR_W-1:0] WAY_FIELD =
      (ONES >> (ADDR_W - WAY_W)) << WAY_SHIFT;
   localparam logic [ADDR_W-1:0] DW_FIELD  =
      (ONES >> (ADDR_W - DW_W)) << DW_SHIFT;

   logic pend_q;
   logic chk_mode_q;
   logic rst_seen_q;

   always_ff @(posedge clk) begin
      rst_seen_q <= rst;
      if (rst) begin
         pend_q     <= 1'b0;
         chk_mode_q <= 1'b0;
      end else begin
         if (rd_req) begin
            pend_q <= 1'b1;
         end else if (rd_valid) begin
            pend_q <= 1'b0;
         end
         if (start && !busy) begin
            chk_mode_q <= check_data;
         end
      end
   end

   p_tag_addr_r1: assert property (@(posedge clk) disable iff (rst)
      (rd_req && !rd_kind) |-> ((rd_addr & ~(WAY_FIELD | IDX_FIELD)) == '0));

   p_data_addr_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_req && rd_kind) |-> ((rd_addr & ~(WAY_FIELD | IDX_FIELD | DW_FIELD)) == '0));

   p_data_gated_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_req && rd_kind) |-> chk_mode_q);

   p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      rd_req |=> !rd_req);

   p_one_outstanding_r3: assert property (@(posedge clk) disable iff (rst)
      rd_req |-> !pend_q);

   p_err_field_r9: assert property (@(posedge clk) disable iff (rst)
      (err_word & ~32'h3000_0000) == 32'h0);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

   p_err_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> $stable(err_word));

   p_start_launch_r11: assert property (@(posedge clk) disable iff (rst)
      (!busy && start) |=> (busy && err_word == 32'h0));

   p_reset_idle_r13: assert property (@(posedge clk)
      (rst_seen_q && !rst) |-> (!busy && !done && !rd_req && err_word == 32'h0));

endmodule

bind ic_parity_scanner ic_parity_scanner_chk #(
   .ADDR_W    (ADDR_W),
   .NUM_WAYS  (NUM_WAYS),
   .NUM_DW    (NUM_DW),
   .WAY_SHIFT (WAY_SHIFT),
   .IDX_MSB   (IDX_MSB),
   .IDX_LSB   (IDX_LSB),
   .DW_SHIFT  (DW_SHIFT)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .start      (start),
   .check_data (check_data),
   .rd_req     (rd_req),
   .rd_kind    (rd_kind),
   .rd_addr    (rd_addr),
   .rd_valid   (rd_valid),
   .busy       (busy),
   .done       (done),
   .err_word   (err_word)
);

// File: tb/ic_parity_scanner_tb_top.sv
`timescale 1ns/1ps
module ic_parity_scanner_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [15:0] set_index = 16'h0;
   logic        check_data = 1'b0;
   logic        rd_req;
   logic        rd_kind;
   logic [15:0] rd_addr;
   logic        rd_valid;
   logic [31:0] rsp_hi;
   logic [63:0] rsp_lo;
   logic        busy;
   logic        done;
   logic [31:0] err_word;
   logic [7:0]  lru_order;

   always #2.5 clk = ~clk;

   ic_parity_scanner dut_i (
      .clk (clk), .rst (rst), .start (start), .set_index (set_index),
      .check_data (check_data), .rd_req (rd_req), .rd_kind (rd_kind),
      .rd_addr (rd_addr), .rd_valid (rd_valid), .rsp_hi (rsp_hi),
      .rsp_lo (rsp_lo), .busy (busy), .done (done), .err_word (err_word),
      .lru_order (lru_order)
   );

   // cache array image
   logic [31:0] m_th [4];
   logic [63:0] m_tl [4];
   logic [31:0] m_dh [4][4];
   logic [63:0] m_dl [4][4];

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int lat_cfg = 0;
   int log_n = 0;
   int r3_viol = 0;
   int last_rsp_cyc = 0;
   logic [15:0] log_addr [64];
   logic        log_kind [64];
   logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rnd(output logic [63:0] r);
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 7);
      seed = seed ^ (seed << 17);
      r = seed;
   endtask

   // array responder: one response per request, lat_cfg extra cycles
   initial begin : responder
      bit          pend;
      int          pcnt;
      logic [15:0] paddr;
      logic        pkind;
      pend = 0; pcnt = 0; paddr = 0; pkind = 0;
      rd_valid = 1'b0; rsp_hi = 32'h0; rsp_lo = 64'h0;
      forever begin
         @(negedge clk);
         rd_valid = 1'b0;
         if (pend) begin
            if (pcnt == 0) begin
               if (pkind) begin
                  rsp_hi = m_dh[paddr[14:13]][paddr[4:3]];
                  rsp_lo = m_dl[paddr[14:13]][paddr[4:3]];
               end else begin
                  rsp_hi = m_th[paddr[14:13]];
                  rsp_lo = m_tl[paddr[14:13]];
               end
               rd_valid = 1'b1;
               pend = 0;
               last_rsp_cyc = cyc;
            end else begin
               pcnt--;
            end
         end
         if (rd_req === 1'b1 && !rst) begin
            if (pend) r3_viol++;
            if (log_n < 64) begin
               log_addr[log_n] = rd_addr;
               log_kind[log_n] = rd_kind;
            end
            log_n++;
            pend = 1; pcnt = lat_cfg; paddr = rd_addr; pkind = rd_kind;
         end
      end
   end

   // fill the array with random content whose parity fields are all correct
   task automatic fill_clean(input logic [3:0] vmask);
      logic [63:0] r;
      for (int w = 0; w < 4; w++) begin
         rnd(r); m_th[w] = r[31:0];
         m_th[w][29] = vmask[w];
         m_th[w][27] = vmask[w];
         rnd(r); m_tl[w] = r;
         m_tl[w][10] = 1'($countones(m_tl[w] & 64'hFFF3FF) % 2);
         m_tl[w][11] = 1'($countones(m_tl[w] >> 24) % 2);
         for (int o = 0; o < 4; o++) begin
            rnd(r); m_dh[w][o] = r[31:0];
            rnd(r); m_dl[w][o] = r;
            m_dh[w][o][16] = 1'($countones(m_dh[w][o][15:8]) % 2);
            for (int j = 0; j < 4; j++) begin
               m_dh[w][o][4+j] = 1'($countones(m_dl[w][o][32+8*j +: 8]) % 2);
               m_dh[w][o][j]   = 1'($countones(m_dl[w][o][8*j +: 8]) % 2);
            end
         end
      end
   endtask

   task automatic run_scan(input logic [15:0] idx, input bit dchk, input bit poke,
                           input logic [31:0] exp_err, input string req);
      int          c;
      int          nexp;
      int          bad;
      int          k;
      int          done_cyc;
      logic [15:0] ea;
      logic [7:0]  exp_lru;
      logic [31:0] err_at_done;
      exp_lru = m_th[0][21:14];
      log_n = 0; r3_viol = 0;
      @(negedge clk);
      start = 1'b1; set_index = idx; check_data = dchk;
      @(negedge clk);
      start = 1'b0;
      c = 0;
      while (done !== 1'b1 && c < 2000) begin
         if (poke && c == 4) begin
            start = 1'b1; set_index = ~idx; check_data = ~dchk;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         c++;
      end
      start = 1'b0;
      done_cyc = cyc;
      err_at_done = err_word;
      chk(done === 1'b1, "R11 done seen", {63'h0, done}, 64'h1);
      chk(done_cyc == last_rsp_cyc + 1, "R11 done one cycle after last response",
          done_cyc, last_rsp_cyc + 1);
      chk(err_word == exp_err, req, err_word, exp_err);
      chk(lru_order == exp_lru, "R10 lru order", lru_order, exp_lru);
      nexp = dchk ? 20 : 4;
      chk(log_n == nexp, dchk ? "R2 read count" : "R2 tag-only read count", log_n, nexp);
      bad = 0; k = 0;
      for (int w = 0; w < 4; w++) begin
         ea = (16'(w) << 13) | (idx & 16'h1FE0);
         if (k < log_n && (log_addr[k] != ea || log_kind[k] != 1'b0)) bad++;
         k++;
         if (dchk) begin
            for (int o = 0; o < 4; o++) begin
               if (k < log_n && (log_addr[k] != (ea | 16'(o << 3)) || log_kind[k] != 1'b1)) bad++;
               k++;
            end
         end
      end
      chk(bad == 0, "R1 R2 address sequence", bad, 0);
      chk(r3_viol == 0, "R3 one outstanding read", r3_viol, 0);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R11 done single pulse", {done, busy}, 0);
      repeat (6) @(negedge clk);
      chk(log_n == nexp, poke ? "R12 no reads from ignored start" : "R3 no extra reads",
          log_n, nexp);
      chk(err_word == err_at_done, "R11 error word held", err_word, err_at_done);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [63:0] r;
      logic [15:0] idx_list [6];
      int          sc;
      idx_list[0] = 16'h0000; idx_list[1] = 16'h1FE0; idx_list[2] = 16'hFFFF;
      idx_list[3] = 16'h0020; idx_list[4] = 16'h0AB7; idx_list[5] = 16'h7345;
      sc = 0;
      fill_clean(4'hF);

      // R13: reset state
      repeat (5) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && rd_req == 1'b0, "R13 idle in reset",
          {busy, done, rd_req}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(err_word == 32'h0 && lru_order == 8'h0, "R13 cleared after reset",
          {err_word, lru_order}, 0);

      // R1 R2: clean lines, many indexes, both modes, varying latency
      for (int i = 0; i < 6; i++) begin
         fill_clean(4'hF);
         lat_cfg = i % 4;
         run_scan(idx_list[i], i[0], 1'b0, 32'h0, "R1 clean set no fault");
      end
      fill_clean(4'b0101);
      run_scan(16'h0140, 1'b1, 1'b0, 32'h0, "R1 clean set with invalid lines");

      // R4: valid copy mismatch, valid and invalid lines
      for (int w = 0; w < 4; w++) begin
         for (int v = 0; v < 2; v++) begin
            fill_clean(4'hF);
            m_th[w][29] = 1'(v); m_th[w][27] = 1'(v);
            m_th[w][27] = ~m_th[w][27];
            lat_cfg = sc % 4; sc++;
            run_scan(16'h1FE0, 1'b0, 1'b0, 32'h2000_0000, "R4 valid copy mismatch");
         end
      end

      // R5 R6: tag segment faults, flipping either the parity bit or a covered bit
      for (int w = 0; w < 4; w++) begin
         for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 2; v++) begin
               for (int p = 0; p < 2; p++) begin
                  fill_clean(4'hF);
                  m_th[w][29] = 1'(v); m_th[w][27] = 1'(v);
                  if (s == 0) begin
                     if (p == 0) m_tl[w][10] = ~m_tl[w][10];
                     else        m_tl[w][3+w*5] = ~m_tl[w][3+w*5];
                  end else begin
                     if (p == 0) m_tl[w][11] = ~m_tl[w][11];
                     else        m_tl[w][24+w*13] = ~m_tl[w][24+w*13];
                  end
                  lat_cfg = sc % 4; sc++;
                  run_scan(16'(w * 16'h0460), 1'(p), 1'b0, v ? 32'h2000_0000 : 32'h0,
                           s == 0 ? (v ? "R5 low segment fault" : "R5 invalid line ignored")
                                  : (v ? "R6 high segment fault" : "R6 invalid line ignored"));
               end
            end
         end
      end

      // R7 R8: every data parity field of every way and doubleword
      for (int w = 0; w < 4; w++) begin
         for (int o = 0; o < 4; o++) begin
            for (int k = 0; k < 9; k++) begin
               fill_clean(4'hF);
               if (k == 8) begin
                  if (o % 2 == 0) m_dh[w][o][16] = ~m_dh[w][o][16];
                  else            m_dh[w][o][8+w+o] = ~m_dh[w][o][8+w+o];
               end else if (k % 2 == 0) begin
                  m_dh[w][o][k] = ~m_dh[w][o][k];
               end else if (k >= 4) begin
                  m_dl[w][o][32+8*(k-4)+((w+o)%8)] = ~m_dl[w][o][32+8*(k-4)+((w+o)%8)];
               end else begin
                  m_dl[w][o][8*k+((w+o)%8)] = ~m_dl[w][o][8*k+((w+o)%8)];
               end
               lat_cfg = sc % 4; sc++;
               run_scan(16'h0A60, 1'b1, 1'b0, 32'h1000_0000,
                        k == 8 ? "R7 predecode parity fault" : "R8 byte parity fault");
            end
         end
         // R2: same kind of fault is invisible with data checking off
         fill_clean(4'hF);
         m_dh[w][1][16] = ~m_dh[w][1][16];
         m_dl[w][2][40] = ~m_dl[w][2][40];
         run_scan(16'h0A60, 1'b0, 1'b0, 32'h0, "R2 data faults ignored when off");
      end

      // R9: faults in several ways merge
      fill_clean(4'hF);
      m_th[1][27] = ~m_th[1][27];
      m_tl[3][40] = ~m_tl[3][40];
      m_dh[0][3][2] = ~m_dh[0][3][2];
      m_dh[2][0][16] = ~m_dh[2][0][16];
      run_scan(16'h1234, 1'b1, 1'b0, 32'h3000_0000, "R9 merged tag and data faults");
      fill_clean(4'hF);
      m_dh[3][3][6] = ~m_dh[3][3][6];
      run_scan(16'h1234, 1'b1, 1'b0, 32'h1000_0000, "R9 data only fault in last way");

      // R10: replacement order from way 0 only
      for (int i = 0; i < 8; i++) begin
         fill_clean(4'hF);
         rnd(r);
         m_th[0][21:14] = r[7:0] ^ 8'(i * 37);
         m_th[1][21:14] = ~m_th[0][21:14];
         m_th[3][21:14] = r[15:8];
         lat_cfg = i % 4;
         run_scan(r[31:16], 1'b0, 1'b0, 32'h0, "R10 no fault with order pattern");
      end

      // R12: start while busy is ignored
      fill_clean(4'hF);
      m_tl[2][5] = ~m_tl[2][5];
      lat_cfg = 1;
      run_scan(16'h0FE0, 1'b1, 1'b1, 32'h2000_0000, "R12 start while busy ignored");
      fill_clean(4'hF);
      lat_cfg = 2;
      run_scan(16'h0040, 1'b0, 1'b1, 32'h0, "R12 start while busy tag only");

      // R13: reset in the middle of a scan
      fill_clean(4'hF);
      m_th[0][27] = ~m_th[0][27];
      lat_cfg = 0;
      @(negedge clk);
      start = 1'b1; set_index = 16'h0100; check_data = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (8) @(negedge clk);
      chk(busy == 1'b1 && err_word == 32'h2000_0000, "R13 scan running before reset",
          {busy, err_word}, {1'b1, 32'h2000_0000});
      rst = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && rd_req == 1'b0 && err_word == 32'h0
          && lru_order == 8'h0, "R13 mid-scan reset idles",
          {busy, done, rd_req, err_word, lru_order}, 0);
      rst = 1'b0;
      repeat (8) @(negedge clk);
      fill_clean(4'hF);
      run_scan(16'h0100, 1'b1, 1'b0, 32'h0, "R13 clean scan after reset");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule